// File: doc/BRIEF.md
# Two-Slot Parallel-Port DMA Channel

This block moves bytes between system memory and a byte-wide parallel-port device. Software prepares up to two buffer descriptors, slot A and slot B. Each descriptor is one 64-bit word that gives a start address, a byte count and an end-of-transfer marker. Software then raises the slot's ready bit in the control word. The engine serves one ready slot at a time. When a slot is done, the engine drops that slot's ready bit and turns to the other slot. Software can therefore refill one slot while the engine drains the other.

A read-only status word shows the slot in use, whether the engine is busy, and a live count of the bytes still to move. The memory side uses a one-byte request/acknowledge port. The device side has a ready/valid pair for each direction, plus a one-cycle terminal-count strobe.

The engine is a state machine with seven states:
- ST_IDLE waits for a ready slot and takes the current slot before the other one.
- ST_CHECK latches the descriptor and vets it. From there it moves to ST_FINISH if the descriptor is bad or empty, to ST_MEM_RD for outbound work, or to ST_DEV_RD for inbound work.
- Outbound bytes loop ST_MEM_RD to ST_DEV_WR (memory acknowledge) and back to ST_MEM_RD (device ready), until the last byte goes to ST_FINISH.
- Inbound bytes loop ST_DEV_RD to ST_MEM_WR (device valid) and back to ST_DEV_RD (memory acknowledge), until the last byte goes to ST_FINISH.
- ST_FINISH clears the slot's ready bit, flips the current slot and returns to ST_IDLE.

Top module: `pp_dma_channel`

## Requirements
- R1: Register offsets are 0 for descriptor A, 1 for descriptor B, 2 for control and 3 for status. A descriptor word keeps its start address in bits 31:0, its byte count in bits 43:32 and its end marker in bit 63. Bits 62:44 read back as zero.
- R2: Control word bits are: 0 direction (0 = memory to device, 1 = device to memory), 1 run, 2 channel clear, 3 slot B ready, 4 slot A ready, and 5 a read-only sticky error bit. After reset the control and status words read zero.
- R3: In outbound mode a count of N sends memory bytes base..base+N-1 to the device, in that order. After power-up, slot A is served first.
- R4: In inbound mode, the i-th byte taken from the device is written to memory address base+i.
- R5: Finishing a slot clears its ready bit and makes the other slot current. If both slots are ready, they are served alternately. If no slot is ready, the engine idles.
- R6: If the end marker is set, dev_tc is high for exactly one cycle, the cycle after the final byte's handshake. If the marker is clear, dev_tc stays low.
- R7: Status bit 0 is the current slot (0 = A). Bit 1 is busy (running and not idle). Bits 13:2 are bytes left: loaded with N and lowered by one for each completed byte.
- R8: While run is 0, no request or handshake is offered and all engine state holds. Setting run to 1 resumes the transfer where it stopped.
- R9: While channel clear is 1, both ready bits, the error bit and the byte count are cleared, slot A becomes current and the engine idles.
- R10: The engine skips a descriptor without any memory or device activity, and without dev_tc, if its base offset within a 4 KiB page plus the count exceeds 4096. It also skips an inbound descriptor whose base bits 5:0 are not zero. A skip clears the slot's ready bit and sets the sticky error bit. A buffer that ends exactly on the page edge is valid.
- R11: If a control write and a slot completion land in the same cycle, the finished slot's ready bit is cleared even when the write carries a 1 for it. The write's value for the other slot's ready bit is kept.
- R12: A count of zero completes at once with no byte moved, and it still strobes dev_tc if the end marker is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register offset for reads and writes |
| reg_wdata | input | 64 | Register write data |
| reg_rdata | output | 64 | Register read data for reg_addr |
| mem_req | output | 1 | Memory byte request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 32 | Memory byte address |
| mem_wdata | output | 8 | Memory write byte |
| mem_ack | input | 1 | Memory accepts the request this cycle |
| mem_rdata | input | 8 | Read byte, valid with mem_ack |
| dev_out_valid | output | 1 | Outbound byte offered to the device |
| dev_out_data | output | 8 | Outbound byte |
| dev_out_ready | input | 1 | Device takes the outbound byte |
| dev_in_valid | input | 1 | Device offers an inbound byte |
| dev_in_data | input | 8 | Inbound byte |
| dev_in_ready | output | 1 | Engine takes the inbound byte |
| dev_tc | output | 1 | One-cycle terminal-count strobe |

## Verification
Slot completion and a software write to the control word can land in the same cycle. The engine clears the finished slot's ready bit while the write tries to set both ready bits. The bench forces this by waiting for the terminal-count strobe of slot A, which marks the ST_FINISH cycle, and issuing the control write in that very cycle. It judges the outcome by two observations: slot B's bytes then reach the device in order, and no byte of slot A appears a second time, so the final control word shows both ready bits low.

// File: rtl/pp_dma_pkg.sv
package pp_dma_pkg;

    localparam int ADDR_W        = 32;
    localparam int LEN_W         = 12;
    localparam int BYTE_W        = 8;
    localparam int WORD_W        = 64;
    localparam int PAGE_BITS     = 12;
    localparam int IN_ALIGN_BITS = 6;

    // descriptor field positions
    localparam int LEN_LSB  = 32;
    localparam int LAST_BIT = 63;

    // register offsets
    localparam logic [1:0] OFS_CTX_A = 2'd0;
    localparam logic [1:0] OFS_CTX_B = 2'd1;
    localparam logic [1:0] OFS_CTL   = 2'd2;
    localparam logic [1:0] OFS_STAT  = 2'd3;

    // control bit positions
    localparam int CB_DIR = 0;
    localparam int CB_RUN = 1;
    localparam int CB_CLR = 2;
    localparam int CB_VB  = 3;
    localparam int CB_VA  = 4;
    localparam int CB_ERR = 5;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CHECK,
        ST_MEM_RD,
        ST_DEV_WR,
        ST_DEV_RD,
        ST_MEM_WR,
        ST_FINISH
    } eng_state_e;

    typedef struct packed {
        logic              last;
        logic [LEN_W-1:0]  len;
        logic [ADDR_W-1:0] base;
    } ctx_t;

    function automatic ctx_t unpack_ctx(input logic [WORD_W-1:0] w);
        ctx_t c;
        c.last = w[LAST_BIT];
        c.len  = w[LEN_LSB +: LEN_W];
        c.base = w[ADDR_W-1:0];
        return c;
    endfunction

    function automatic logic [WORD_W-1:0] pack_ctx(input ctx_t c);
        logic [WORD_W-1:0] w;
        w = '0;
        w[LAST_BIT]           = c.last;
        w[LEN_LSB +: LEN_W]   = c.len;
        w[ADDR_W-1:0]         = c.base;
        return w;
    endfunction

endpackage

// File: rtl/pp_dma_ctx_check.sv
module pp_dma_ctx_check
    import pp_dma_pkg::*;
#(
    parameter int P_BITS = PAGE_BITS,
    parameter int A_BITS = IN_ALIGN_BITS
) (
    input  ctx_t ctx,
    input  logic dir_in,
    output logic bad,
    output logic empty
);
    localparam int SUM_W = P_BITS + 1;
    localparam logic [SUM_W-1:0] PAGE_SIZE = SUM_W'(1) << P_BITS;

    logic [SUM_W-1:0] end_off;
    logic             bad_page;
    logic             bad_align;

    assign end_off  = SUM_W'(ctx.base[P_BITS-1:0]) + SUM_W'(ctx.len);
    assign bad_page = end_off > PAGE_SIZE;

    generate
        if (A_BITS > 0) begin : g_align
            assign bad_align = dir_in && (ctx.base[A_BITS-1:0] != '0);
        end else begin : g_no_align
            assign bad_align = 1'b0;
        end
    endgenerate

    assign bad   = bad_page || bad_align;
    assign empty = (ctx.len == '0);

endmodule

// File: rtl/pp_dma_regs.sv
module pp_dma_regs
    import pp_dma_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        addr,
    input  logic [WORD_W-1:0] wr_data,
    output logic [WORD_W-1:0] rd_data,
    input  logic [WORD_W-1:0] stat_word,
    input  logic              clr_valid,
    input  logic              clr_sel,
    input  logic              set_err,
    output ctx_t              ctx_a,
    output ctx_t              ctx_b,
    output logic              ctl_dir,
    output logic              ctl_run,
    output logic              ctl_clr,
    output logic [1:0]        slot_valid,
    output logic              err_flag
);
    ctx_t       ctx_q [2];
    logic [1:0] valid_d;
    logic       ctl_wr;
    logic       unused_bits;

    assign ctl_wr      = wr_en && (addr == OFS_CTL);
    assign unused_bits = ^{wr_data[WORD_W-1:CB_ERR]};

    generate
        for (genvar g = 0; g < 2; g++) begin : g_ctx
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    ctx_q[g] <= '0;
                end else if (wr_en && (addr == 2'(g))) begin
                    ctx_q[g] <= unpack_ctx(wr_data);
                end
            end
        end
    endgenerate

    assign ctx_a = ctx_q[0];
    assign ctx_b = ctx_q[1];

    always_comb begin
        valid_d = slot_valid;
        if (ctl_wr) begin
            valid_d = {wr_data[CB_VB], wr_data[CB_VA]};
        end
        if (clr_valid) begin
            valid_d[clr_sel] = 1'b0;
        end
        if (ctl_clr) begin
            valid_d = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_dir    <= 1'b0;
            ctl_run    <= 1'b0;
            ctl_clr    <= 1'b0;
            slot_valid <= '0;
            err_flag   <= 1'b0;
        end else begin
            if (ctl_wr) begin
                ctl_dir <= wr_data[CB_DIR];
                ctl_run <= wr_data[CB_RUN];
                ctl_clr <= wr_data[CB_CLR];
            end
            slot_valid <= valid_d;
            if (ctl_clr) begin
                err_flag <= 1'b0;
            end else if (set_err) begin
                err_flag <= 1'b1;
            end
        end
    end

    always_comb begin
        rd_data = '0;
        unique case (addr)
            OFS_CTX_A: rd_data = pack_ctx(ctx_q[0]);
            OFS_CTX_B: rd_data = pack_ctx(ctx_q[1]);
            OFS_CTL: begin
                rd_data[CB_DIR] = ctl_dir;
                rd_data[CB_RUN] = ctl_run;
                rd_data[CB_CLR] = ctl_clr;
                rd_data[CB_VB]  = slot_valid[1];
                rd_data[CB_VA]  = slot_valid[0];
                rd_data[CB_ERR] = err_flag;
            end
            default:   rd_data = stat_word;
        endcase
    end

    // R11
    clr_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr_valid |=> !slot_valid[$past(clr_sel)]);

    // R9
    clear_inval_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_clr |=> (slot_valid == 2'b00) && !err_flag);

endmodule

// File: rtl/pp_dma_engine.sv
module pp_dma_engine
    import pp_dma_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  ctx_t              ctx_a,
    input  ctx_t              ctx_b,
    input  logic [1:0]        slot_valid,
    input  logic              ctl_dir,
    input  logic              ctl_run,
    input  logic              ctl_clr,
    input  logic              mem_ack,
    input  logic [BYTE_W-1:0] mem_rdata,
    input  logic              dev_out_ready,
    input  logic              dev_in_valid,
    input  logic [BYTE_W-1:0] dev_in_data,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [BYTE_W-1:0] mem_wdata,
    output logic              dev_out_valid,
    output logic [BYTE_W-1:0] dev_out_data,
    output logic              dev_in_ready,
    output logic              dev_tc,
    output logic              clr_valid,
    output logic              clr_sel,
    output logic              set_err,
    output logic              cur_sel,
    output logic              busy,
    output logic [LEN_W-1:0]  bytes_left
);
    eng_state_e        state_q, state_d;
    logic [LEN_W-1:0]  cnt_q;
    logic [ADDR_W-1:0] addr_q;
    logic [BYTE_W-1:0] byte_q;
    logic              cur_q;
    logic              dir_q;
    logic              tc_arm_q;
    logic              run;
    logic              byte_done;
    logic              last_byte;
    ctx_t              sel_ctx;
    logic              ctx_bad;
    logic              ctx_empty;

    assign run       = ctl_run && !ctl_clr;
    assign sel_ctx   = cur_q ? ctx_b : ctx_a;
    assign last_byte = (cnt_q == LEN_W'(1));
    assign byte_done = run && (((state_q == ST_DEV_WR) && dev_out_ready) ||
                               ((state_q == ST_MEM_WR) && mem_ack));

    pp_dma_ctx_check #(
        .P_BITS (PAGE_BITS),
        .A_BITS (IN_ALIGN_BITS)
    ) i_check (
        .ctx    (sel_ctx),
        .dir_in (ctl_dir),
        .bad    (ctx_bad),
        .empty  (ctx_empty)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        if (ctl_clr) begin
            state_d = ST_IDLE;
        end else if (ctl_run) begin
            unique case (state_q)
                ST_IDLE:   if (|slot_valid) state_d = ST_CHECK;
                ST_CHECK: begin
                    if (ctx_bad || ctx_empty) state_d = ST_FINISH;
                    else if (ctl_dir)         state_d = ST_DEV_RD;
                    else                      state_d = ST_MEM_RD;
                end
                ST_MEM_RD: if (mem_ack)       state_d = ST_DEV_WR;
                ST_DEV_WR: if (dev_out_ready) state_d = last_byte ? ST_FINISH : ST_MEM_RD;
                ST_DEV_RD: if (dev_in_valid)  state_d = ST_MEM_WR;
                ST_MEM_WR: if (mem_ack)       state_d = last_byte ? ST_FINISH : ST_DEV_RD;
                ST_FINISH:                    state_d = ST_IDLE;
                default:                      state_d = ST_IDLE;
            endcase
        end
    end

    // datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q    <= '0;
            addr_q   <= '0;
            byte_q   <= '0;
            cur_q    <= 1'b0;
            dir_q    <= 1'b0;
            tc_arm_q <= 1'b0;
        end else if (ctl_clr) begin
            cnt_q    <= '0;
            addr_q   <= '0;
            cur_q    <= 1'b0;
            tc_arm_q <= 1'b0;
        end else if (ctl_run) begin
            unique case (state_q)
                ST_IDLE: begin
                    if (!slot_valid[cur_q] && slot_valid[!cur_q]) cur_q <= !cur_q;
                end
                ST_CHECK: begin
                    cnt_q    <= sel_ctx.len;
                    addr_q   <= sel_ctx.base;
                    dir_q    <= ctl_dir;
                    tc_arm_q <= sel_ctx.last && !ctx_bad;
                end
                ST_MEM_RD: if (mem_ack)      byte_q <= mem_rdata;
                ST_DEV_RD: if (dev_in_valid) byte_q <= dev_in_data;
                ST_FINISH: cur_q <= !cur_q;
                default: ;
            endcase
            if (byte_done) begin
                cnt_q  <= cnt_q - LEN_W'(1);
                addr_q <= addr_q + ADDR_W'(1);
            end
        end
    end

    // outputs
    always_comb begin
        mem_req       = 1'b0;
        mem_we        = 1'b0;
        dev_out_valid = 1'b0;
        dev_in_ready  = 1'b0;
        dev_tc        = 1'b0;
        clr_valid     = 1'b0;
        set_err       = 1'b0;
        if (run) begin
            unique case (state_q)
                ST_MEM_RD: mem_req = 1'b1;
                ST_MEM_WR: begin
                    mem_req = 1'b1;
                    mem_we  = 1'b1;
                end
                ST_DEV_WR: dev_out_valid = 1'b1;
                ST_DEV_RD: dev_in_ready  = 1'b1;
                ST_CHECK:  set_err       = ctx_bad;
                ST_FINISH: begin
                    clr_valid = 1'b1;
                    dev_tc    = tc_arm_q;
                end
                default: ;
            endcase
        end
    end

    assign mem_addr     = addr_q;
    assign mem_wdata    = byte_q;
    assign dev_out_data = byte_q;
    assign clr_sel      = cur_q;
    assign cur_sel      = cur_q;
    assign busy         = run && (state_q != ST_IDLE);
    assign bytes_left   = cnt_q;

    // R6
    tc_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dev_tc |=> !dev_tc);

    // R8
    freeze_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctl_run && !ctl_clr) |=> $stable(state_q) && $stable(cnt_q) && $stable(addr_q));

    // R9
    clear_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_clr |=> (state_q == ST_IDLE) && (cnt_q == '0) && !cur_q);

    // R7
    count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        byte_done |=> cnt_q == $past(cnt_q) - LEN_W'(1));

    // R3
    one_side_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({mem_req, dev_out_valid, dev_in_ready}));

    // R10
    skip_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_CHECK && run && ctx_bad) |=> (state_q == ST_FINISH) && !dev_tc);

endmodule

// File: rtl/pp_dma_channel.sv
module pp_dma_channel
    import pp_dma_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_wr,
    input  logic [1:0]  reg_addr,
    input  logic [63:0] reg_wdata,
    output logic [63:0] reg_rdata,
    output logic        mem_req,
    output logic        mem_we,
    output logic [31:0] mem_addr,
    output logic [7:0]  mem_wdata,
    input  logic        mem_ack,
    input  logic [7:0]  mem_rdata,
    output logic        dev_out_valid,
    output logic [7:0]  dev_out_data,
    input  logic        dev_out_ready,
    input  logic        dev_in_valid,
    input  logic [7:0]  dev_in_data,
    output logic        dev_in_ready,
    output logic        dev_tc
);
    localparam int PAD_W = WORD_W - LEN_W - 2;

    ctx_t              ctx_a, ctx_b;
    logic              ctl_dir, ctl_run, ctl_clr;
    logic [1:0]        slot_valid;
    logic              err_flag;
    logic              clr_valid, clr_sel, set_err;
    logic              cur_sel, busy;
    logic [LEN_W-1:0]  bytes_left;
    logic [WORD_W-1:0] stat_word;
    logic              unused_err;

    assign stat_word  = {{PAD_W{1'b0}}, bytes_left, busy, cur_sel};
    assign unused_err = err_flag;

    pp_dma_regs i_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (reg_wr),
        .addr       (reg_addr),
        .wr_data    (reg_wdata),
        .rd_data    (reg_rdata),
        .stat_word  (stat_word),
        .clr_valid  (clr_valid),
        .clr_sel    (clr_sel),
        .set_err    (set_err),
        .ctx_a      (ctx_a),
        .ctx_b      (ctx_b),
        .ctl_dir    (ctl_dir),
        .ctl_run    (ctl_run),
        .ctl_clr    (ctl_clr),
        .slot_valid (slot_valid),
        .err_flag   (err_flag)
    );

    pp_dma_engine i_engine (
        .clk           (clk),
        .rst_n         (rst_n),
        .ctx_a         (ctx_a),
        .ctx_b         (ctx_b),
        .slot_valid    (slot_valid),
        .ctl_dir       (ctl_dir),
        .ctl_run       (ctl_run),
        .ctl_clr       (ctl_clr),
        .mem_ack       (mem_ack),
        .mem_rdata     (mem_rdata),
        .dev_out_ready (dev_out_ready),
        .dev_in_valid  (dev_in_valid),
        .dev_in_data   (dev_in_data),
        .mem_req       (mem_req),
        .mem_we        (mem_we),
        .mem_addr      (mem_addr),
        .mem_wdata     (mem_wdata),
        .dev_out_valid (dev_out_valid),
        .dev_out_data  (dev_out_data),
        .dev_in_ready  (dev_in_ready),
        .dev_tc        (dev_tc),
        .clr_valid     (clr_valid),
        .clr_sel       (clr_sel),
        .set_err       (set_err),
        .cur_sel       (cur_sel),
        .busy          (busy),
        .bytes_left    (bytes_left)
    );

endmodule

// File: tb/test_pp_dma_channel.sv
`timescale 1ns/1ps
module test_pp_dma_channel;

    localparam logic [63:0] C_DIR = 64'h1, C_RUN = 64'h2, C_CLR = 64'h4,
                            C_VB  = 64'h8, C_VA = 64'h10, C_ERR = 64'h20;

    logic        clk = 1'b0, rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [1:0]  reg_addr = 2'd0;
    logic [63:0] reg_wdata = '0, reg_rdata;
    logic        mem_req, mem_we, mem_ack = 1'b0;
    logic [31:0] mem_addr;
    logic [7:0]  mem_wdata, mem_rdata = '0;
    logic        dev_out_valid, dev_out_ready = 1'b0;
    logic [7:0]  dev_out_data;
    logic        dev_in_valid = 1'b0, dev_in_ready;
    logic [7:0]  dev_in_data = '0;
    logic        dev_tc;

    pp_dma_channel i_pp_dma_channel (.*);

    always #10 clk = ~clk;

    int n_tests = 0, n_fail = 0;
    int cyc = 0, hs_cnt = 0, last_hs = -10, tc_cnt = 0, act_cnt = 0;
    bit ready_en = 1'b1, tc_timed = 1'b1, done = 1'b0;
    logic [7:0]  mem_m [0:8191];
    logic [7:0]  exp_dev [$];
    logic [20:0] exp_w [$];
    logic [7:0]  src_q [$];

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic report();
        if (!done) begin
            done = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    endtask

    function automatic logic [63:0] mk(input logic [31:0] b, input logic [11:0] n, input bit l);
        return {l, 19'd0, n, b};
    endfunction

    // device and memory models; scoreboard monitor
    always @(negedge clk) begin
        cyc++;
        if (dev_tc) begin
            tc_cnt++;
            if (tc_timed) chk(cyc == last_hs + 1, "R6", "tc cycle", 64'(cyc), 64'(last_hs + 1));
        end
        mem_ack = 1'b0; dev_out_ready = 1'b0; dev_in_valid = 1'b0;
        if (mem_req || dev_out_valid || dev_in_ready) act_cnt++;
        if (mem_req) begin
            mem_ack = 1'b1;
            if (mem_we) begin
                if (exp_w.size() == 0) chk(1'b0, "R4", "unexpected mem write", {mem_addr, mem_wdata}, 0);
                else begin
                    logic [20:0] e;
                    e = exp_w.pop_front();
                    chk({mem_addr[12:0], mem_wdata} == e, "R4", "mem write", {mem_addr[12:0], mem_wdata}, e);
                end
                mem_m[mem_addr[12:0]] = mem_wdata;
                hs_cnt++; last_hs = cyc;
            end else begin
                mem_rdata = mem_m[mem_addr[12:0]];
            end
        end
        if (dev_out_valid && ready_en) begin
            dev_out_ready = 1'b1;
            if (exp_dev.size() == 0) chk(1'b0, "R3", "unexpected device byte", dev_out_data, 0);
            else begin
                logic [7:0] e;
                e = exp_dev.pop_front();
                chk(dev_out_data == e, "R3", "device byte", dev_out_data, e);
            end
            hs_cnt++; last_hs = cyc;
        end
        if (dev_in_ready && src_q.size() > 0) begin
            dev_in_valid = 1'b1;
            dev_in_data  = src_q.pop_front();
        end
    end

    task automatic wr(input logic [1:0] a, input logic [63:0] d);
        @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk); reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [63:0] d);
        @(negedge clk); reg_addr = a; #1; d = reg_rdata;
    endtask

    // driver: expected items into the scoreboard queues
    task automatic push_out(input int base, input int n);
        for (int i = 0; i < n; i++) exp_dev.push_back(mem_m[13'(base + i)]);
    endtask

    task automatic push_in(input int base, input int n, input int seed);
        for (int i = 0; i < n; i++) begin
            logic [7:0] b;
            b = 8'(seed + 3 * i);
            src_q.push_back(b);
            exp_w.push_back({13'(base + i), b});
        end
    endtask

    task automatic wait_idle(input string req);
        logic [63:0] c, s;
        for (int k = 0; k < 3000; k++) begin
            rd(2'd2, c); rd(2'd3, s);
            if (c[4:3] == 2'b00 && s[1] == 1'b0) return;
        end
        chk(1'b0, req, "timeout waiting for idle", 0, 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        chk(1'b0, "ALL", "watchdog expired", 0, 0);
        report();
    end

    initial begin
        logic [63:0] d;
        int h0, t0, a0;
        for (int i = 0; i < 8192; i++) mem_m[i] = 8'(i * 7 + 3);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // reset state
        rd(2'd2, d); chk(d == 0, "R2", "control after reset", d, 0);
        rd(2'd3, d); chk(d == 0, "R7", "status after reset", d, 0);
        chk(mem_req == 0, "R2", "idle memory port", mem_req, 0);

        // descriptor read-back with reserved bits dropped
        wr(2'd0, mk(32'h100, 12'd5, 1'b1) | 64'h7FFF_F000_0000_0000);
        rd(2'd0, d); chk(d == mk(32'h100, 12'd5, 1'b1), "R1", "descriptor read-back", d, mk(32'h100, 12'd5, 1'b1));

        // outbound on slot A, end marker set
        push_out(32'h100, 5); t0 = tc_cnt;
        wr(2'd2, C_RUN | C_VA); wait_idle("R3");
        chk(exp_dev.size() == 0, "R3", "bytes outstanding", exp_dev.size(), 0);
        chk(tc_cnt == t0 + 1, "R6", "tc count", tc_cnt, t0 + 1);
        rd(2'd3, d); chk(d == 64'h1, "R5", "slot B current after A", d, 64'h1);

        // inbound on slot B, no end marker
        wr(2'd1, mk(32'h240, 12'd4, 1'b0)); push_in(32'h240, 4, 8'h50); t0 = tc_cnt;
        wr(2'd2, C_RUN | C_DIR | C_VB); wait_idle("R4");
        chk(exp_w.size() == 0, "R4", "writes outstanding", exp_w.size(), 0);
        chk(tc_cnt == t0, "R6", "no tc without marker", tc_cnt, t0);

        // both slots ready: A then B
        wr(2'd0, mk(32'h300, 12'd3, 1'b0)); wr(2'd1, mk(32'h400, 12'd2, 1'b0));
        push_out(32'h300, 3); push_out(32'h400, 2);
        wr(2'd2, C_RUN | C_VA | C_VB); wait_idle("R5");
        chk(exp_dev.size() == 0, "R5", "ping-pong order", exp_dev.size(), 0);

        // status word during a stall
        ready_en = 1'b0;
        wr(2'd0, mk(32'h500, 12'd7, 1'b0)); push_out(32'h500, 7);
        wr(2'd2, C_RUN | C_VA); repeat (5) @(negedge clk);
        rd(2'd3, d); chk(d == 64'h1E, "R7", "status busy count 7", d, 64'h1E);
        ready_en = 1'b1; wait_idle("R7");
        rd(2'd3, d); chk(d == 64'h1, "R7", "status after drain", d, 64'h1);

        // freeze on slot B
        ready_en = 1'b0;
        wr(2'd1, mk(32'h600, 12'd6, 1'b1)); push_out(32'h600, 6); t0 = tc_cnt;
        wr(2'd2, C_RUN | C_VB); repeat (4) @(negedge clk);
        wr(2'd2, C_VB); h0 = hs_cnt; ready_en = 1'b1;
        repeat (20) @(negedge clk);
        chk(hs_cnt == h0, "R8", "no handshake while frozen", hs_cnt, h0);
        rd(2'd3, d); chk(d == 64'h19, "R8", "status held while frozen", d, 64'h19);
        wr(2'd2, C_RUN | C_VB); wait_idle("R8");
        chk(exp_dev.size() == 0, "R8", "resumed transfer done", exp_dev.size(), 0);
        chk(tc_cnt == t0 + 1, "R6", "tc after resume", tc_cnt, t0 + 1);

        // zero-length slot A with marker
        tc_timed = 1'b0; h0 = hs_cnt; t0 = tc_cnt;
        wr(2'd0, mk(32'h700, 12'd0, 1'b1)); wr(2'd2, C_RUN | C_VA); wait_idle("R12");
        chk(tc_cnt == t0 + 1, "R12", "tc for empty buffer", tc_cnt, t0 + 1);
        chk(hs_cnt == h0, "R12", "no bytes moved", hs_cnt, h0);
        tc_timed = 1'b1;

        // bad descriptors: misaligned inbound on B, page crossing on A
        a0 = act_cnt; t0 = tc_cnt;
        wr(2'd1, mk(32'h241, 12'd4, 1'b0)); wr(2'd2, C_RUN | C_DIR | C_VB); wait_idle("R10");
        chk(act_cnt == a0, "R10", "misaligned skipped quietly", act_cnt, a0);
        rd(2'd2, d); chk(d == (C_RUN | C_DIR | C_ERR), "R10", "error set", d, C_RUN | C_DIR | C_ERR);
        wr(2'd0, mk(32'hFFE, 12'd4, 1'b1)); wr(2'd2, C_RUN | C_VA); wait_idle("R10");
        chk(act_cnt == a0, "R10", "page crossing skipped", act_cnt, a0);
        chk(tc_cnt == t0, "R10", "no tc on skip", tc_cnt, t0);
        rd(2'd2, d); chk(d == (C_RUN | C_ERR), "R10", "error sticky", d, C_RUN | C_ERR);
        wr(2'd1, mk(32'hFFC, 12'd4, 1'b0)); push_out(32'hFFC, 4);
        wr(2'd2, C_RUN | C_VB); wait_idle("R10");
        chk(exp_dev.size() == 0, "R10", "buffer ending on page edge runs", exp_dev.size(), 0);

        // channel clear mid-transfer
        ready_en = 1'b0;
        wr(2'd0, mk(32'h800, 12'd5, 1'b0)); push_out(32'h800, 5);
        wr(2'd2, C_RUN | C_VA); repeat (4) @(negedge clk);
        wr(2'd2, C_RUN | C_CLR); repeat (2) @(negedge clk);
        rd(2'd2, d); chk(d == (C_RUN | C_CLR), "R9", "ready and error cleared", d, C_RUN | C_CLR);
        rd(2'd3, d); chk(d == 0, "R9", "status cleared", d, 0);
        exp_dev.delete(); h0 = hs_cnt; ready_en = 1'b1;
        wr(2'd2, C_RUN); repeat (10) @(negedge clk);
        chk(hs_cnt == h0, "R9", "no transfer after clear", hs_cnt, h0);

        // completion and control write in the same cycle
        wr(2'd0, mk(32'h900, 12'd2, 1'b1)); wr(2'd1, mk(32'hA00, 12'd3, 1'b0));
        push_out(32'h900, 2); push_out(32'hA00, 3);
        wr(2'd2, C_RUN | C_VA);
        begin
            int k;
            for (k = 0; k < 200; k++) begin
                @(negedge clk);
                if (dev_tc) break;
            end
            chk(k < 200, "R11", "finish cycle reached", k, 0);
        end
        reg_wr = 1'b1; reg_addr = 2'd2; reg_wdata = C_RUN | C_VA | C_VB;
        @(negedge clk); reg_wr = 1'b0;
        wait_idle("R11");
        chk(exp_dev.size() == 0, "R11", "slot B served after collision", exp_dev.size(), 0);
        rd(2'd2, d); chk(d == C_RUN, "R11", "finished slot stays cleared", d, C_RUN);

        repeat (5) @(negedge clk);
        report();
    end

endmodule